// File: doc/BRIEF.md
# Cascadable BCD Decade Counter Chain

This block counts in binary-coded decimal across a configurable number of decimal digits. Each digit is a modulo-10 stage that holds a 4-bit code. A stage can be preset from a parallel input, cleared at once by an active-low clear, and advanced by two count enables. All digits share one clock, one clear, one load strobe and one count enable. The terminal-count flag of each digit lets the digits above it advance.

The second enable of each digit is formed by look-ahead logic. It is the AND of the "at nine" conditions of every lower digit, so a carry does not have to ripple through the digits one stage at a time. When every digit reads nine, the top-level carry output goes high. A further chain can use it as its own enable.

Top module: `bcd_chain`

## Requirements
- R1: While `rst_n` is low, every digit of `count` is 0 at once, with no clock edge needed.
- R2: With `load_n` low at a rising edge, `count` takes the value of `preset` whatever the value of `cnt_en`. Digit k sits in bits [4k+3:4k].
- R3: With `load_n` high and `cnt_en` high, digit 0 increments by one at each rising edge.
- R4: A digit that reads 9 and is enabled returns to 0 at the edge.
- R5: With `load_n` high and `cnt_en` low, `count` holds its value across edges.
- R6: An enabled digit that holds a code from 10 to 15 goes to 0 at the next edge. The digit above it does not advance because of it.
- R7: A digit's terminal count is high exactly when the digit reads 9 and its second enable is high. It is combinational, with no register delay.
- R8: Digit k (k>0) advances only when `cnt_en` is high and all lower digits read 9. For example, 0999 goes to 1000 in one edge.
- R9: `carry_out` is high exactly while every digit reads 9, independent of `cnt_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low clear |
| load_n | input | 1 | Synchronous active-low parallel load |
| cnt_en | input | 1 | Count enable shared by all digits |
| preset | input | 4*DIGITS | Parallel load value, digit k in bits [4k+3:4k] |
| count | output | 4*DIGITS | Current BCD count |
| carry_out | output | 1 | High while all digits read 9 |

## Verification
The hardest state to reach from the ports is a multi-digit rollover, where several digits must reach 9 at the same time. The stimulus reaches it by presetting values just below the boundary (0995, 9997) and then counting across 0999→1000 and 9999→0000. Codes above 9 never arise from counting, so they are injected through the parallel load, including an illegal code in a higher digit that sits above a 9.

// File: rtl/bcd_chain.sv
module bcd_stage (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_n,
  input  logic       en_a,
  input  logic       en_b,
  input  logic [3:0] preset,
  output logic [3:0] q,
  output logic       tc
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              q <= '0;
    else if (!load_n)        q <= preset;
    else if (en_a && en_b)   q <= (q >= 4'd9) ? 4'd0 : q + 4'd1;

  assign tc = (q == 4'd9) && en_b;

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> q == $past(preset));
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_n && en_a && en_b && q < 4'd9 |=> q == 4'($past(q) + 4'd1));
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_n && en_a && en_b && q >= 4'd9 |=> q == 4'd0);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_n && !(en_a && en_b) |=> $stable(q));
endmodule

module bcd_chain #(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_n,
  input  logic                cnt_en,
  input  logic [4*DIGITS-1:0] preset,
  output logic [4*DIGITS-1:0] count,
  output logic                carry_out
);
  logic [DIGITS-1:0] nine, en_b, tc;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    assign nine[i] = count[4*i +: 4] == 4'd9;
    if (i == 0) begin : g_lsd
      assign en_b[i] = 1'b1;
    end else begin : g_up
      assign en_b[i] = &nine[i-1:0];
    end
    bcd_stage u_stage (
      .clk(clk), .rst_n(rst_n), .load_n(load_n),
      .en_a(cnt_en), .en_b(en_b[i]),
      .preset(preset[4*i +: 4]), .q(count[4*i +: 4]), .tc(tc[i])
    );
  end

  assign carry_out = &tc;

  assert_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> &nine);
  assert_tcnine_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tc[DIGITS-1] |-> nine[DIGITS-1]);
endmodule

// File: tb/sim_bcd_chain.sv
module sim_bcd_chain;
  localparam int D = 4;
  logic clk = 0, rst_n = 0, load_n = 1, cnt_en = 0;
  logic [4*D-1:0] preset = '0, count;
  logic carry_out;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [4*D-1:0] model = '0;
  logic [4*D-1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  bcd_chain #(.DIGITS(D)) u0 (.clk(clk), .rst_n(rst_n), .load_n(load_n),
    .cnt_en(cnt_en), .preset(preset), .count(count), .carry_out(carry_out));

  function automatic logic all_nine(logic [4*D-1:0] v);
    for (int k = 0; k < D; k++) if (v[4*k +: 4] != 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(string tag, logic [4*D-1:0] act, logic [4*D-1:0] exp,
                       logic act_c, logic exp_c);
    checks++;
    if (act !== exp || act_c !== exp_c) begin
      errors++;
      $display("FAIL %s count=%h carry=%b expected count=%h carry=%b",
               tag, act, act_c, exp, exp_c);
    end
  endtask

  // driver: set inputs at falling edge, push predicted post-edge count
  task automatic step(string tag, logic ld_n, logic en, logic [4*D-1:0] pv);
    logic [4*D-1:0] nxt;
    logic lower_nine;
    @(negedge clk);
    load_n = ld_n; cnt_en = en; preset = pv;
    nxt = model;
    if (!ld_n) nxt = pv;
    else if (en) begin
      lower_nine = 1'b1;
      for (int k = 0; k < D; k++) begin
        if (lower_nine)
          nxt[4*k +: 4] = (model[4*k +: 4] >= 4'd9) ? 4'd0 : model[4*k +: 4] + 4'd1;
        lower_nine = lower_nine && (model[4*k +: 4] == 4'd9);
      end
    end
    model = nxt;
    exp_q.push_back(nxt);
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [4*D-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, count, e, carry_out, all_nine(e));
    end
  end

  initial begin
    #20000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #1 check("R1 reset", count, '0, carry_out, 1'b0);
    @(negedge clk); rst_n = 1;
    step("R2 load overrides enable", 1'b0, 1'b1, 16'h0995);
    for (int n = 0; n < 10; n++) step("R3 R4 R8 count across 0999", 1'b1, 1'b1, '0);
    for (int n = 0; n < 3; n++) step("R5 hold", 1'b1, 1'b0, 16'hFFFF);
    step("R2 load 9997", 1'b0, 1'b0, 16'h9997);
    for (int n = 0; n < 3; n++) step("R8 R9 rollover 9999", 1'b1, 1'b1, '0);
    step("R2 load 9999", 1'b0, 1'b1, 16'h9999);
    step("R9 carry without enable", 1'b1, 1'b0, '0);
    step("R2 load 000C", 1'b0, 1'b0, 16'h000C);
    step("R6 illegal code clears, no carry", 1'b1, 1'b1, '0);
    step("R2 load 00F9", 1'b0, 1'b0, 16'h00F9);
    step("R6 R7 illegal upper digit", 1'b1, 1'b1, '0);
    step("R2 load 0008", 1'b0, 1'b0, 16'h0008);
    step("R7 digit 9 lifts next", 1'b1, 1'b1, '0);
    step("R7 carry into tens", 1'b1, 1'b1, '0);
    repeat (2) @(negedge clk);
    load_n = 0; preset = 16'h4321; cnt_en = 1;
    #2 rst_n = 0;
    #1 check("R1 async clear mid-cycle", count, '0, carry_out, 1'b0);
    @(negedge clk); load_n = 1; cnt_en = 0; rst_n = 1; model = '0;
    step("R5 hold after clear", 1'b1, 1'b0, '0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule